// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

A purely combinational integer ALU for a 32-bit datapath, assembled from a row of identical one-bit slices. Each slice holds a full adder, an AND gate, an OR gate and a four-way selector. A shared three-bit control word picks the operation: bitwise AND, bitwise OR, addition, subtraction, or a signed set-on-less-than. Carries ripple upward from slice to slice.

A single negate line does two jobs. It inverts operand B inside every slice, and it forces the carry into the lowest slice to one. Subtraction therefore comes out of the same adder as A + ~B + 1. For set-on-less-than, the signed outcome of that subtraction (the sign bit corrected by overflow) is routed back into the lowest slice's "less" input. Every other slice sees a constant zero there.

A zero flag, the NOR of the selected result, serves equal and not-equal branch decisions: subtract, then test the flag or its complement. Carry-out and signed overflow always describe the adder's effective operation.

Top module: `alu_bitslice`

## Requirements
- R1: Control code 3'b000 (negate=0, select=00) drives the result with A AND B.
- R2: Control code 3'b001 (negate=0, select=01) drives the result with A OR B.
- R3: Control code 3'b010 (negate=0, select=10) drives the result with (A + B) mod 2^32.
- R4: Control code 3'b110 (negate=1, select=10) drives the result with (A - B) mod 2^32.
- R5: carry_o is bit 32 of the unsigned sum A + B when control bit 2 is 0. When control bit 2 is 1, carry_o is 1 exactly when A >= B taken as unsigned numbers.
- R6: ovf_o is 1 exactly when the signed two's-complement result of the effective operation (A+B when control bit 2 is 0, A-B when it is 1) lies outside [-2^31, 2^31-1].
- R7: Control code 3'b111 drives result bit 0 with 1 when A < B as signed numbers, including when A-B overflows, and drives all other result bits with 0.
- R8: zero_o is 1 exactly when the 32-bit result output is all zeros, for every control code. Under code 3'b110 it is therefore 1 exactly when A equals B.
- R9: Control code 3'b011 (negate=0, select=11) drives an all-zero result, and zero_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| ctrl_i | input | 3 | Bit 2 negate, bits 1:0 result select |
| result_o | output | 32 | Selected result |
| zero_o | output | 1 | Result is all zeros |
| carry_o | output | 1 | Carry out of the top slice |
| ovf_o | output | 1 | Signed overflow of the effective add |

## Verification
The block holds no state, so a wrong carry or a wrong mux select shows on the outputs in the same cycle as the operands that provoke it. A broken ripple link shows only when a carry has to cross it: all-ones plus one, and operands near the signed limits. The corner set applies these cases to every control code. A missing or inverted feedback of the less-than result shows only under the less-than code. It is exposed by operand pairs whose subtraction overflows, which is where sign-only and sign-xor-overflow comparisons give different answers.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } sel_e;

    typedef struct packed {
        logic negate;
        sel_e sel;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Carry out of a one-bit full adder.
    function automatic logic fa_carry(input logic x, input logic y, input logic ci);
        return (x & y) | (ci & (x | y));
    endfunction

    // Signed overflow of an addition, from the operand and sum sign bits.
    function automatic logic add_ovf(input logic sx, input logic sy, input logic ss);
        return (sx == sy) && (ss != sx);
    endfunction

endpackage

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic  a,
    input  logic  b,
    input  logic  cin,
    input  logic  less,
    input  ctrl_t ctrl,
    output logic  res,
    output logic  sum,
    output logic  cout
);
    logic b_eff;

    assign b_eff = b ^ ctrl.negate;
    assign sum   = a ^ b_eff ^ cin;
    assign cout  = fa_carry(a, b_eff, cin);

    always_comb begin
        unique case (ctrl.sel)
            SEL_AND:  res = a & b_eff;
            SEL_OR:   res = a | b_eff;
            SEL_SUM:  res = sum;
            SEL_LESS: res = less;
            default:  res = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_chain.sv
module alu_chain
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] less,
    input  ctrl_t        ctrl,
    output logic [W-1:0] res,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic carry [0:W];

    assign carry[0] = ctrl.negate;
    assign cout     = carry[W];

    for (genvar i = 0; i < W; i++) begin : g_slice
        alu_slice u_slice (
            .a    (a[i]),
            .b    (b[i]),
            .cin  (carry[i]),
            .less (less[i]),
            .ctrl (ctrl),
            .res  (res[i]),
            .sum  (sum[i]),
            .cout (carry[i+1])
        );
    end
endmodule

// File: rtl/alu_flags.sv
module alu_flags
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] res,
    input  logic         a_msb,
    input  logic         b_msb,
    input  logic         sum_msb,
    input  logic         negate,
    output logic         zero,
    output logic         ovf,
    output logic         lt
);
    assign zero = ~|res;
    assign ovf  = add_ovf(a_msb, b_msb ^ negate, sum_msb);
    assign lt   = sum_msb ^ ovf;
endmodule

// File: rtl/alu_bitslice.sv
module alu_bitslice
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic [W-1:0]      result_o,
    output logic              zero_o,
    output logic              carry_o,
    output logic              ovf_o
);
    localparam int MSB = W - 1;

    ctrl_t        ctrl;
    logic [W-1:0] sum;
    logic [W-1:0] less_vec;
    logic         lt;

    assign ctrl     = ctrl_t'(ctrl_i);
    assign less_vec = {{(W-1){1'b0}}, ctrl.negate & lt};

    alu_chain #(.W(W)) u_chain (
        .a    (a_i),
        .b    (b_i),
        .less (less_vec),
        .ctrl (ctrl),
        .res  (result_o),
        .sum  (sum),
        .cout (carry_o)
    );

    alu_flags #(.W(W)) u_flags (
        .res     (result_o),
        .a_msb   (a_i[MSB]),
        .b_msb   (b_i[MSB]),
        .sum_msb (sum[MSB]),
        .negate  (ctrl.negate),
        .zero    (zero_o),
        .ovf     (ovf_o),
        .lt      (lt)
    );

    always_comb begin
        if (ctrl_i == 3'b000)
            AST_AND_SUBSET: assert ((result_o & ~a_i) == '0); // R1
        if (ctrl_i == 3'b001)
            AST_OR_COVERS: assert ((result_o & a_i) == a_i); // R2
        if (ctrl_i == 3'b010 && a_i[MSB] != b_i[MSB])
            AST_NO_OVERFLOW: assert (!ovf_o); // R6
        if (ctrl_i == 3'b110 && a_i == b_i)
            AST_EQUAL_SUB: assert (zero_o && carry_o); // R8
        if (ctrl_i == 3'b111)
            AST_LESS_RANGE: assert (result_o[W-1:1] == '0); // R7
        if (ctrl_i == 3'b011)
            AST_SPARE_CODE: assert (result_o == '0 && zero_o); // R9
    end
endmodule

// File: tb/alu_bitslice_tb.sv
module alu_bitslice_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a, b;
    logic [2:0]  ctrl;
    logic [31:0] res;
    logic        zero, cy, ov;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    alu_bitslice u_dut (
        .a_i(a), .b_i(b), .ctrl_i(ctrl),
        .result_o(res), .zero_o(zero), .carry_o(cy), .ovf_o(ov)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (a=%h b=%h ctrl=%b)", tag, what, act, exp, a, b, ctrl);
        end
    endtask

    task automatic apply(input logic [31:0] va, input logic [31:0] vb, input logic [2:0] vc);
        longint sa, sb, sr;
        logic [32:0] u;
        logic [31:0] er;
        logic ec, eo, ez;
        string tag;
        @(posedge clk);
        a = va; b = vb; ctrl = vc;
        sa = longint'($signed(va));
        sb = longint'($signed(vb));
        if (vc[2]) begin
            sr = sa - sb;
            ec = (va >= vb);
            u  = {1'b0, va} - {1'b0, vb};
        end else begin
            sr = sa + sb;
            u  = {1'b0, va} + {1'b0, vb};
            ec = u[32];
        end
        eo = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        case (vc)
            3'b000: begin er = va & vb;   tag = "R1"; end
            3'b001: begin er = va | vb;   tag = "R2"; end
            3'b010: begin er = u[31:0];   tag = "R3"; end
            3'b110: begin er = u[31:0];   tag = "R4"; end
            3'b111: begin er = (sa < sb) ? 32'd1 : 32'd0; tag = "R7"; end
            default: begin er = 32'd0;    tag = "R9"; end
        endcase
        ez = (er == 32'd0);
        @(negedge clk);
        n_vec++;
        chk(tag,  "result", res, er);
        chk("R8", "zero",   {31'd0, zero}, {31'd0, ez});
        chk("R5", "carry",  {31'd0, cy},   {31'd0, ec});
        chk("R6", "ovf",    {31'd0, ov},   {31'd0, eo});
    endtask

    logic [31:0] corner [0:9];
    logic [2:0]  codes  [0:5];

    initial begin
        corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
        corner[2] = 32'hFFFF_FFFF; corner[3] = 32'h7FFF_FFFF;
        corner[4] = 32'h8000_0000; corner[5] = 32'h8000_0001;
        corner[6] = 32'h5555_5555; corner[7] = 32'hAAAA_AAAA;
        corner[8] = 32'h0000_FFFF; corner[9] = 32'h7FFF_FFFE;
        codes[0] = 3'b000; codes[1] = 3'b001; codes[2] = 3'b010;
        codes[3] = 3'b110; codes[4] = 3'b111; codes[5] = 3'b011;
        a = '0; b = '0; ctrl = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset-state style check: all-zero inputs, AND code (R1, R8)
        apply(32'd0, 32'd0, 3'b000);
        for (int c = 0; c < 6; c++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    apply(corner[i], corner[j], codes[c]);
        // R7 overflow cases: A-B overflows yet comparison must hold
        apply(32'h8000_0000, 32'h0000_0001, 3'b111);
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);
        for (int k = 0; k < 3000; k++)
            apply($urandom, $urandom, codes[k % 6]);
        for (int k = 0; k < 200; k++) begin
            logic [31:0] r;
            r = $urandom;
            apply(r, r, 3'b110); // R8 equality
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule